// File: doc/BRIEF.md
# Triggered SPI Program Replay Unit

This block holds a short list of 16-bit SPI engine instructions together with a table of static transmit words. It replays both to a downstream SPI execution core every time an external hardware trigger fires, with no processor involved per transfer. Software fills the two memories through append-only load ports. It arms the unit with an enable level and empties it with a flush level.

During a replay the stored instructions are offered in order on a valid/ready command stream. Stored transmit words are offered in order on a second valid/ready stream, which the core pulls from whenever an instruction needs write data. Received words from the core pass straight through to an external streaming sink; none are kept. When the replay hands off the terminating sync instruction, the unit pulses a completion event.

Each memory's depth is reported as a pair of log2 address widths, so that software can size its programs.

Top module: `rpl_replay_unit`

## Requirements
- R1: Each cycle with `cmd_load_en` high and `flush` low, while fewer than 2^CAW instructions are stored, appends `cmd_load_data` after the last stored instruction.
- R2: Each cycle with `dat_load_en` high and `flush` low, while fewer than 2^DAW words are stored, appends `dat_load_data` after the last stored word.
- R3: `mem_widths[7:0]` equals CAW and `mem_widths[15:8]` equals DAW. The defaults are 4 and 4, giving 16 entries each.
- R4: A `trigger` starts a replay (`busy` rises on the next cycle) only when `enable` is high, `flush` is low, no replay is running and at least one instruction is stored. Otherwise the trigger is ignored.
- R5: During a replay, `cmd_valid` presents stored instructions 0 to N-1 in order, advancing on each `cmd_valid && cmd_ready`. `busy` falls on the cycle after the last instruction is handed off, and `cmd_valid` is low whenever `busy` is low.
- R6: While `busy` is high and unconsumed words remain, `sdo_valid` presents stored words in order from word 0, advancing on each `sdo_valid && sdo_ready`. Otherwise `sdo_valid` is low.
- R7: Every accepted trigger restarts both the instruction index and the word index at entry 0, so each replay repeats the same sequence.
- R8: `done` pulses for exactly one cycle, on the cycle after the instruction 16'h3000 (bits 15:12 = 3 for sync, bits 11:8 = 0, sync ID in bits 7:0 = 0) is handed off. A sync instruction with a nonzero ID produces no pulse.
- R9: While `flush` is high, a running replay stops, both memories read as empty, both overflow flags clear, and loads and triggers are ignored.
- R10: A load into a full memory is dropped and sets that memory's overflow flag (`cmd_overflow` or `dat_overflow`). The flag stays set until a flush.
- R11: `rx_out_valid` and `rx_out_data` equal `rx_in_valid` and `rx_in_data` of the previous cycle, whether or not a replay is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms the trigger input |
| flush | input | 1 | Empties both memories and aborts a replay while high |
| trigger | input | 1 | Hardware start request |
| cmd_load_en | input | 1 | Append strobe for the instruction memory |
| cmd_load_data | input | 16 | Instruction to append |
| dat_load_en | input | 1 | Append strobe for the transmit-word memory |
| dat_load_data | input | DW | Transmit word to append |
| cmd_valid | output | 1 | Instruction stream valid |
| cmd_ready | input | 1 | Instruction stream ready from the core |
| cmd_data | output | 16 | Current instruction |
| sdo_valid | output | 1 | Transmit-word stream valid |
| sdo_ready | input | 1 | Transmit-word stream ready from the core |
| sdo_data | output | DW | Current transmit word |
| rx_in_valid | input | 1 | Received word valid from the core |
| rx_in_data | input | DW | Received word from the core |
| rx_out_valid | output | 1 | Received word valid toward the sink |
| rx_out_data | output | DW | Received word toward the sink |
| busy | output | 1 | Replay in progress |
| done | output | 1 | One-cycle completion event |
| cmd_overflow | output | 1 | Sticky dropped-instruction flag |
| dat_overflow | output | 1 | Sticky dropped-word flag |
| mem_widths | output | 16 | Log2 depths: [7:0] instruction, [15:8] word |

## Verification
Replays are run with both streams always ready, and then with the two ready inputs toggling out of phase. The second pattern separates a design that advances on `valid` alone from one that waits for the handshake, and shows that the two indices move independently. Triggers are sent while the unit is disarmed, during a running replay, and with an empty program. Only the armed, idle, non-empty case may start, and the repeated runs must restart from entry 0. Filling a memory past its depth, flushing it, and replaying a program that ends in a nonzero-ID sync show the overflow flag, the empty state and the absence of a completion pulse.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

  localparam int CMD_W = 16;
  localparam logic [3:0] OP_SYNC = 4'h3;

  // Terminating instruction: sync opcode, zero sub-field, ID zero.
  function automatic logic is_final_sync(input logic [CMD_W-1:0] w);
    return (w[15:12] == OP_SYNC) && (w[11:8] == 4'h0) && (w[7:0] == 8'h00);
  endfunction

  // True when the entry at ptr is the last one of cnt stored entries.
  function automatic logic ptr_at_last(input logic [8:0] ptr, input logic [8:0] cnt);
    return (ptr + 9'd1) >= cnt;
  endfunction

  function automatic logic [15:0] pack_widths(input int caw, input int daw);
    return {8'(daw), 8'(caw)};
  endfunction

endpackage

// File: rtl/rpl_store.sv
module rpl_store #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [AW:0]   count,
  output logic          overflow
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic full;
  logic append_ev;
  logic drop_ev;

  assign full      = (count == FULL_CNT);
  assign append_ev = wr_en && !flush && !full;
  assign drop_ev   = wr_en && !flush && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (append_ev) count <= count + 1'b1;
      if (drop_ev)   overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (append_ev) mem[count[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  assert_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_drop_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> overflow);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flush |=> overflow);
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !overflow);
  assert_append_R1: assert property (@(posedge clk) disable iff (!rst_n)
    append_ev |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/rpl_seq.sv
module rpl_seq
  import rpl_pkg::*;
#(
  parameter int CAW = 4,
  parameter int DAW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            flush,
  input  logic            trigger,
  input  logic [CAW:0]    cmd_cnt,
  input  logic [DAW:0]    dat_cnt,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic            cmd_ready,
  input  logic            sdo_ready,
  output logic [CAW-1:0]  cmd_idx,
  output logic [DAW-1:0]  dat_idx,
  output logic            cmd_valid,
  output logic            sdo_valid,
  output logic            busy,
  output logic            done
);
  logic [CAW:0] cmd_ptr;
  logic [DAW:0] dat_ptr;
  logic start_ev;
  logic cmd_fire;
  logic sdo_fire;
  logic last_fire;

  assign start_ev  = enable && trigger && !busy && !flush && (cmd_cnt != '0);
  assign cmd_valid = busy && (cmd_ptr < cmd_cnt);
  assign sdo_valid = busy && (dat_ptr < dat_cnt);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign sdo_fire  = sdo_valid && sdo_ready;
  assign last_fire = cmd_fire && ptr_at_last(9'(cmd_ptr), 9'(cmd_cnt));
  assign cmd_idx   = cmd_ptr[CAW-1:0];
  assign dat_idx   = dat_ptr[DAW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cmd_ptr <= '0;
      dat_ptr <= '0;
      done    <= 1'b0;
    end else begin
      done <= cmd_fire && is_final_sync(cmd_word);
      if (flush) begin
        busy <= 1'b0;
      end else if (start_ev) begin
        busy    <= 1'b1;
        cmd_ptr <= '0;
        dat_ptr <= '0;
      end else begin
        if (cmd_fire) cmd_ptr <= cmd_ptr + 1'b1;
        if (last_fire) busy <= 1'b0;
        if (sdo_fire) dat_ptr <= dat_ptr + 1'b1;
      end
    end
  end

  assert_valid_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire && !flush |=> !busy);
  assert_trigger_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trigger && !cmd_fire && !flush |=> $stable(cmd_ptr));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy && (cmd_ptr == '0) && (dat_ptr == '0));
  assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_fire));
  assert_sdo_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_valid |-> busy);
  assert_flush_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy);

endmodule

// File: rtl/rpl_replay_unit.sv
module rpl_replay_unit
  import rpl_pkg::*;
#(
  parameter int CAW = 4,
  parameter int DAW = 4,
  parameter int DW  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             flush,
  input  logic             trigger,
  input  logic             cmd_load_en,
  input  logic [CMD_W-1:0] cmd_load_data,
  input  logic             dat_load_en,
  input  logic [DW-1:0]    dat_load_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [CMD_W-1:0] cmd_data,
  output logic             sdo_valid,
  input  logic             sdo_ready,
  output logic [DW-1:0]    sdo_data,
  input  logic             rx_in_valid,
  input  logic [DW-1:0]    rx_in_data,
  output logic             rx_out_valid,
  output logic [DW-1:0]    rx_out_data,
  output logic             busy,
  output logic             done,
  output logic             cmd_overflow,
  output logic             dat_overflow,
  output logic [15:0]      mem_widths
);
  logic [CAW:0]   cmd_cnt;
  logic [DAW:0]   dat_cnt;
  logic [CAW-1:0] cmd_idx;
  logic [DAW-1:0] dat_idx;

  rpl_store #(.W(CMD_W), .AW(CAW)) u_cmd_mem (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(cmd_load_en), .wr_data(cmd_load_data),
    .rd_idx(cmd_idx), .rd_data(cmd_data),
    .count(cmd_cnt), .overflow(cmd_overflow)
  );

  rpl_store #(.W(DW), .AW(DAW)) u_dat_mem (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(dat_load_en), .wr_data(dat_load_data),
    .rd_idx(dat_idx), .rd_data(sdo_data),
    .count(dat_cnt), .overflow(dat_overflow)
  );

  rpl_seq #(.CAW(CAW), .DAW(DAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush),
    .trigger(trigger), .cmd_cnt(cmd_cnt), .dat_cnt(dat_cnt),
    .cmd_word(cmd_data), .cmd_ready(cmd_ready), .sdo_ready(sdo_ready),
    .cmd_idx(cmd_idx), .dat_idx(dat_idx),
    .cmd_valid(cmd_valid), .sdo_valid(sdo_valid),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_out_valid <= 1'b0;
      rx_out_data  <= '0;
    end else begin
      rx_out_valid <= rx_in_valid;
      rx_out_data  <= rx_in_data;
    end
  end

  assign mem_widths = pack_widths(CAW, DAW);

  assert_rx_fwd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid |=> rx_out_valid && (rx_out_data == $past(rx_in_data)));
  assert_rx_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_in_valid |=> !rx_out_valid);

endmodule

// File: tb/rpl_replay_unit_bench.sv
module rpl_replay_unit_bench;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, flush = 1'b0, trigger = 1'b0;
  logic cmd_load_en = 1'b0, dat_load_en = 1'b0;
  logic [15:0] cmd_load_data = '0;
  logic [DW-1:0] dat_load_data = '0;
  logic cmd_ready = 1'b0, sdo_ready = 1'b0;
  logic rx_in_valid = 1'b0;
  logic [DW-1:0] rx_in_data = '0;
  logic cmd_valid, sdo_valid, rx_out_valid, busy, done, cmd_overflow, dat_overflow;
  logic [15:0] cmd_data, mem_widths;
  logic [DW-1:0] sdo_data, rx_out_data;

  int checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
  bit finished = 0, compare_on = 0;

  always #2.5 clk = ~clk;

  rpl_replay_unit u_rpl_replay_unit (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush), .trigger(trigger),
    .cmd_load_en(cmd_load_en), .cmd_load_data(cmd_load_data),
    .dat_load_en(dat_load_en), .dat_load_data(dat_load_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
    .busy(busy), .done(done), .cmd_overflow(cmd_overflow),
    .dat_overflow(dat_overflow), .mem_widths(mem_widths)
  );

  // Behavioural reference model
  logic [15:0] cq[$];
  logic [DW-1:0] dq[$];
  int m_cp = 0, m_dp = 0;
  bit m_busy = 0, m_done = 0, m_covf = 0, m_dovf = 0, m_rxv = 0;
  logic [DW-1:0] m_rxd = '0;

  always @(posedge clk) begin
    bit cfire, dfire, st;
    if (!rst_n) begin
      cq.delete(); dq.delete();
      m_cp = 0; m_dp = 0; m_busy = 0; m_done = 0; m_covf = 0; m_dovf = 0;
      m_rxv = 0; m_rxd = '0;
    end else begin
      cfire = m_busy && (m_cp < cq.size()) && cmd_ready;
      dfire = m_busy && (m_dp < dq.size()) && sdo_ready;
      m_done = cfire && (cq[m_cp] == 16'h3000);
      m_rxv = rx_in_valid; m_rxd = rx_in_data;
      if (flush) begin
        cq.delete(); dq.delete(); m_covf = 0; m_dovf = 0; m_busy = 0;
      end else begin
        st = enable && trigger && !m_busy && (cq.size() != 0);
        if (st) begin
          m_busy = 1; m_cp = 0; m_dp = 0;
        end else begin
          if (cfire) begin
            m_cp++;
            if (m_cp >= cq.size()) m_busy = 0;
          end
          if (dfire) m_dp++;
        end
        if (cmd_load_en) begin
          if (cq.size() < DEPTH) cq.push_back(cmd_load_data); else m_covf = 1;
        end
        if (dat_load_en) begin
          if (dq.size() < DEPTH) dq.push_back(dat_load_data); else m_dovf = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit ecv, edv;
    cyc++;
    if (compare_on && rst_n) begin
      ecv = m_busy && (m_cp < cq.size());
      edv = m_busy && (m_dp < dq.size());
      chk("R4 busy", DW'(busy), DW'(m_busy));
      chk("R5 cmd_valid", DW'(cmd_valid), DW'(ecv));
      if (ecv) chk("R5 cmd_data", DW'(cmd_data), DW'(cq[m_cp]));
      chk("R6 sdo_valid", DW'(sdo_valid), DW'(edv));
      if (edv) chk("R6 sdo_data", sdo_data, dq[m_dp]);
      chk("R8 done", DW'(done), DW'(m_done));
      chk("R10 cmd_overflow", DW'(cmd_overflow), DW'(m_covf));
      chk("R10 dat_overflow", DW'(dat_overflow), DW'(m_dovf));
      chk("R11 rx_out_valid", DW'(rx_out_valid), DW'(m_rxv));
      chk("R11 rx_out_data", rx_out_data, m_rxd);
      chk("R3 mem_widths", DW'(mem_widths), 32'h0000_0404);
    end
  end

  // Background stimulus: ready patterns and receive traffic
  initial begin
    forever begin
      @(negedge clk);
      rx_in_valid = (cyc % 3) != 0;
      rx_in_data = DW'(cyc * 32'h0101_0007);
      if (rdy_mode == 0) begin
        cmd_ready = 1'b1; sdo_ready = 1'b1;
      end else begin
        cmd_ready = cyc[0]; sdo_ready = ~cyc[1];
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cmd(input logic [15:0] w);
    cmd_load_en = 1'b1; cmd_load_data = w; step(1); cmd_load_en = 1'b0;
  endtask

  task automatic load_dat(input logic [DW-1:0] w);
    dat_load_en = 1'b1; dat_load_data = w; step(1); dat_load_en = 1'b0;
  endtask

  task automatic pulse_trigger;
    trigger = 1'b1; step(1); trigger = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    compare_on = 1;
    step(1);
    chk("R5 reset cmd_valid", DW'(cmd_valid), 0);
    chk("R4 reset busy", DW'(busy), 0);
    chk("R3 reset widths", DW'(mem_widths), 32'h404);

    // Program: config write, chip-select, transfer, final sync
    load_cmd(16'h2103); load_cmd(16'h10FE); load_cmd(16'h0302); load_cmd(16'h3000);
    load_dat(32'hA5A5_0001); load_dat(32'h5A5A_0002); load_dat(32'hC3C3_0003);

    // Disarmed trigger ignored (R4)
    pulse_trigger();
    chk("R4 disarmed trigger ignored", DW'(busy), 0);

    enable = 1'b1;
    pulse_trigger();
    chk("R1 first instruction", DW'(cmd_data), 32'h2103);
    chk("R2 first word", sdo_data, 32'hA5A5_0001);
    step(1);
    pulse_trigger();  // while busy: ignored
    step(8);
    chk("R5 replay finished", DW'(busy), 0);

    // Out-of-phase ready patterns, second replay restarts at entry 0 (R7)
    rdy_mode = 1;
    pulse_trigger();
    chk("R7 restart instruction", DW'(cmd_data), 32'h2103);
    chk("R7 restart word", sdo_data, 32'hA5A5_0001);
    step(25);
    pulse_trigger();
    step(25);
    rdy_mode = 0;

    // Overflow both memories (R10)
    for (int i = 0; i < 14; i++) load_cmd(16'h0000 + 16'(i));
    for (int i = 0; i < 15; i++) load_dat(32'h1000 + 32'(i));
    chk("R10 cmd overflow set", DW'(cmd_overflow), 1);
    chk("R10 dat overflow set", DW'(dat_overflow), 1);
    pulse_trigger();
    step(4);
    flush = 1'b1;  // abort mid-replay (R9)
    step(1);
    chk("R9 flush aborts", DW'(busy), 0);
    load_cmd(16'h0301);  // ignored during flush
    flush = 1'b0;
    step(1);
    chk("R9 overflow cleared", DW'(cmd_overflow), 0);
    pulse_trigger();
    chk("R9 empty program not started", DW'(busy), 0);

    // Nonzero-ID sync: no completion event (R8)
    load_cmd(16'h0300); load_cmd(16'h3005);
    load_dat(32'hDEAD_BEEF);
    pulse_trigger();
    step(6);
    chk("R8 no done for nonzero id", DW'(done), 0);
    load_cmd(16'h3000);
    pulse_trigger();
    step(8);
    enable = 1'b0;
    pulse_trigger();
    step(4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule